// File: doc/BRIEF.md
# Memoryless CPU Opcode Injection Responder

This block stands in for all memory on the data bus of an 8-bit microprocessor. Every byte the processor fetches is chosen from only the three lowest address lines. Those eight slots spell out a tiny loop: load an immediate value into the Y register, store Y to an absolute address in page 0x40, then three break opcodes that send execution back to slot 0. The immediate value and the low address byte are not fixed. They come from a pair of live registers, so the loop keeps writing one chosen byte into one chosen register of a peripheral mapped at 0x4000 and up.

A host controller loads each new pair over a four-wire serial link. The link is mode 0, MSB first, and one frame is sixteen bits: the offset byte first, then the data byte. An interrupt marks the moment the processor fetches the offset byte, which tells the host that the current pair has been consumed and the next one can be sent. The host can also hold the processor in reset while it preloads the first pair.

All pins are sampled on the fast system clock `clk`. This clock is much faster than the processor bus, whose cycle is twelve processor input clocks long. Every output is registered and reflects the inputs sampled one `clk` edge earlier. That is well inside one bus cycle.

Top module: `opinj_responder`

## Requirements
- R1: While `rst_n` is low at a clock edge, after that edge `bus_dout` is 0x00, `bus_oe`, `host_irq` and `cpu_rst_n` are 0, and the live data and offset bytes are cleared to 0x00.
- R2: `cpu_addr` (A2..A0 as an unsigned 3-bit slot number) alone selects the byte. One clock after slot 0 is sampled, `bus_dout` is 0xA0. After slot 2 it is 0x8C. After slot 4 it is 0x40.
- R3: One clock after slot 1 is sampled, `bus_dout` is the live data byte. After slot 3 it is the live offset byte. Exactly one byte source (fixed opcode, data, or offset) is selected at any time.
- R4: One clock after slot 5, 6 or 7 is sampled, `bus_dout` is 0x00.
- R5: `host_irq` is 1 exactly in the clock after an edge that samples slot 3 with `cpu_rnw` = 1, and is 0 otherwise.
- R6: `bus_oe` equals `cpu_rnw` AND `cpu_phi2` as sampled one clock earlier, so the bus is never driven during a write cycle (`cpu_rnw` = 0).
- R7: `cpu_rst_n` equals the inverse of `host_hold` sampled one clock earlier.
- R8: A serial frame is clocked in while `spi_cs_n` is low. It uses mode 0 (MOSI sampled on rising `spi_sck`), MSB first, and has 16 bits: bits 15..8 are the offset byte and bits 7..0 are the data byte.
- R9: A frame that has any number of `spi_sck` rising edges other than 16 is discarded. The live bytes keep their values.
- R10: A valid frame is taken into the live bytes at the second clock edge after the first edge that samples `spi_cs_n` high. If `cpu_addr` is 1 or 3 at that edge, the update waits for the first later edge where it is neither. The live bytes never change at an edge that samples slot 1 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 3 | Processor address bits A2..A0 (slot number) |
| cpu_rnw | input | 1 | Processor read (1) / write (0) |
| cpu_phi2 | input | 1 | Processor bus clock, high during the data phase |
| spi_sck | input | 1 | Host serial clock |
| spi_cs_n | input | 1 | Host serial chip select, active low |
| spi_mosi | input | 1 | Host serial data in |
| host_hold | input | 1 | Host request to hold the processor in reset |
| bus_dout | output | 8 | Byte presented to the processor data bus |
| bus_oe | output | 1 | Data bus output enable |
| host_irq | output | 1 | Interrupt to host: offset byte being fetched |
| cpu_rst_n | output | 1 | Processor reset, active low |

## Verification
Assertions check the following on every cycle: the slot-to-opcode mapping, the data and offset slots matching the live bytes, the single selected source, the enable dropping on writes, the interrupt timing, the reset hold, and the rule that the live bytes stay frozen while slot 1 or 3 is sampled. Some behaviour only the bench scenarios can show. These are the serial framing (bit order, offset-before-data, rejection of 12- and 20-bit frames), the exact commit latency after chip select rises, and the deferral of a commit made while the processor sits on slot 1. Frames sent while the address is cycling also exercise commits that land between slots.

// File: rtl/opinj_pkg.sv
// Shared constants and types for the opcode injection responder.
// Assumes a processor with an 8-bit data bus whose immediate Y load,
// absolute Y store and break opcodes are 0xA0, 0x8C and 0x00.
package opinj_pkg;
    localparam int BYTE_W = 8;
    localparam int SLOT_W = 3;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [SLOT_W-1:0] slot_t;

    localparam byte_t OP_LDY_IMM = 8'hA0;
    localparam byte_t OP_STY_ABS = 8'h8C;
    localparam byte_t PAGE_HI    = 8'h40;
    localparam byte_t OP_BRK     = 8'h00;

    localparam slot_t SLOT_LDY  = 3'd0;
    localparam slot_t SLOT_DATA = 3'd1;
    localparam slot_t SLOT_STY  = 3'd2;
    localparam slot_t SLOT_OFF  = 3'd3;
    localparam slot_t SLOT_PAGE = 3'd4;

    // One-hot byte source selection.
    typedef struct packed {
        logic op;
        logic dat;
        logic off;
    } src_en_t;
endpackage

// File: rtl/opinj_spi_rx.sv
// Serial receiver for host frames (mode 0, MSB first).
// Synchronises SCK, CS_N and MOSI into the clk domain and counts SCK
// rising edges while CS_N is low. When CS_N rises it flags frame_ok
// only if exactly FRAME_BITS bits were seen. Assumes each SCK level
// is held for several clk periods.
module opinj_spi_rx #(
    parameter int FRAME_BITS  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sck,
    input  logic                  cs_n,
    input  logic                  mosi,
    output logic [FRAME_BITS-1:0] word,
    output logic                  frame_ok
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(FRAME_BITS);

    logic [SYNC_STAGES-1:0] sck_sh, cs_sh, mosi_sh;
    logic                   sck_d, cs_d;
    logic                   sck_s, cs_s, mosi_s;
    logic [CNT_W-1:0]       bit_cnt;
    logic [FRAME_BITS-1:0]  shreg;

    assign sck_s  = sck_sh[SYNC_STAGES-1];
    assign cs_s   = cs_sh[SYNC_STAGES-1];
    assign mosi_s = mosi_sh[SYNC_STAGES-1];

    // Synchroniser chains plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_sh  <= '0;
            cs_sh   <= '1;
            mosi_sh <= '0;
            sck_d   <= 1'b0;
            cs_d    <= 1'b1;
        end else begin
            for (int i = SYNC_STAGES - 1; i > 0; i--) begin
                sck_sh[i]  <= sck_sh[i-1];
                cs_sh[i]   <= cs_sh[i-1];
                mosi_sh[i] <= mosi_sh[i-1];
            end
            sck_sh[0]  <= sck;
            cs_sh[0]   <= cs_n;
            mosi_sh[0] <= mosi;
            sck_d      <= sck_s;
            cs_d       <= cs_s;
        end
    end

    // Shift in MOSI on each SCK rise inside a frame and count the bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (cs_s) begin
            bit_cnt <= '0;
        end else if (sck_s && !sck_d) begin
            shreg <= {shreg[FRAME_BITS-2:0], mosi_s};
            if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign word     = shreg;
    assign frame_ok = cs_s && !cs_d && (bit_cnt == CNT_GOOD);

    // The counter is cleared whenever the frame is closed.
    p_cnt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (bit_cnt == '0));
endmodule

// File: rtl/opinj_slot_mux.sv
// Maps the 3-bit slot number to the byte for the data bus and to a
// one-hot source enable. Slots 1 and 3 take the live data and offset
// bytes. All others take a fixed opcode or operand. Purely combinational.
module opinj_slot_mux
    import opinj_pkg::*;
(
    input  slot_t   slot,
    input  byte_t   data_byte,
    input  byte_t   off_byte,
    output byte_t   bus_byte,
    output src_en_t src
);
    byte_t op_byte;

    // Decode the slot into a source select and a fixed opcode value.
    always_comb begin
        src     = '0;
        op_byte = OP_BRK;
        case (slot)
            SLOT_LDY:  op_byte = OP_LDY_IMM;
            SLOT_DATA: src.dat = 1'b1;
            SLOT_STY:  op_byte = OP_STY_ABS;
            SLOT_OFF:  src.off = 1'b1;
            SLOT_PAGE: op_byte = PAGE_HI;
            default:   op_byte = OP_BRK;
        endcase
        src.op = !(src.dat || src.off);
    end

    // Choose the byte from the single enabled source.
    always_comb begin
        if (src.dat)      bus_byte = data_byte;
        else if (src.off) bus_byte = off_byte;
        else              bus_byte = op_byte;
    end

    // Exactly one byte source at a time.
    always_comb begin
        p_one_src_r3: assert ($onehot({src.op, src.dat, src.off}));
    end
endmodule

// File: rtl/opinj_responder.sv
// Top of the opcode injection responder. Presents a data/store/break
// loop to a memoryless processor, with the store's data and low
// address byte taken from live registers that a host loads by serial
// frames. Assumes clk is much faster than the processor bus cycle.
// All outputs are registered.
module opinj_responder
    import opinj_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] cpu_addr,
    input  logic       cpu_rnw,
    input  logic       cpu_phi2,
    input  logic       spi_sck,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    input  logic       host_hold,
    output logic [7:0] bus_dout,
    output logic       bus_oe,
    output logic       host_irq,
    output logic       cpu_rst_n
);
    localparam int FRAME_BITS = 2 * BYTE_W;

    logic [FRAME_BITS-1:0] rx_word;
    logic                  frame_ok;
    byte_t                 live_dat, live_off, held_dat, held_off;
    logic                  pend;
    logic                  busy;
    byte_t                 mux_byte;
    src_en_t               mux_src;

    opinj_spi_rx #(
        .FRAME_BITS (FRAME_BITS),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck     (spi_sck),
        .cs_n    (spi_cs_n),
        .mosi    (spi_mosi),
        .word    (rx_word),
        .frame_ok(frame_ok)
    );

    opinj_slot_mux u_mux (
        .slot     (cpu_addr),
        .data_byte(live_dat),
        .off_byte (live_off),
        .bus_byte (mux_byte),
        .src      (mux_src)
    );

    assign busy = (cpu_addr == SLOT_DATA) || (cpu_addr == SLOT_OFF);

    // Commit a received pair, deferring while a live byte is being fetched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_dat <= '0;
            live_off <= '0;
            held_dat <= '0;
            held_off <= '0;
            pend     <= 1'b0;
        end else if (frame_ok && !busy) begin
            live_off <= rx_word[FRAME_BITS-1:BYTE_W];
            live_dat <= rx_word[BYTE_W-1:0];
            pend     <= 1'b0;
        end else if (frame_ok) begin
            held_off <= rx_word[FRAME_BITS-1:BYTE_W];
            held_dat <= rx_word[BYTE_W-1:0];
            pend     <= 1'b1;
        end else if (pend && !busy) begin
            live_off <= held_off;
            live_dat <= held_dat;
            pend     <= 1'b0;
        end
    end

    // Register the bus byte, enable, interrupt and processor reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_dout  <= '0;
            bus_oe    <= 1'b0;
            host_irq  <= 1'b0;
            cpu_rst_n <= 1'b0;
        end else begin
            bus_dout  <= mux_byte;
            bus_oe    <= cpu_rnw && cpu_phi2;
            host_irq  <= (cpu_addr == SLOT_OFF) && cpu_rnw;
            cpu_rst_n <= !host_hold;
        end
    end

    p_ldy_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr == SLOT_LDY) |=> (bus_dout == OP_LDY_IMM));
    p_page_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr == SLOT_PAGE) |=> (bus_dout == PAGE_HI));
    p_data_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr == SLOT_DATA) |=> (bus_dout == $past(live_dat)));
    p_off_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr == SLOT_OFF) |=> (bus_dout == $past(live_off)));
    p_brk_slots_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr > SLOT_PAGE) |=> (bus_dout == OP_BRK));
    p_irq_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_addr == SLOT_OFF) && cpu_rnw) |=> host_irq);
    p_irq_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !((cpu_addr == SLOT_OFF) && cpu_rnw) |=> !host_irq);
    p_no_drive_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rnw |=> !bus_oe);
    p_hold_cpu_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_hold |=> !cpu_rst_n);
    p_live_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(live_dat) && $stable(live_off)));
endmodule

// File: tb/opinj_responder_test.sv
// Bench for opinj_responder: a behavioural reference model is updated
// on each rising clock and compared with the outputs on each falling clock.
module opinj_responder_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cpu_addr = 3'd0;
    logic       cpu_rnw = 1'b1;
    logic       cpu_phi2 = 1'b0;
    logic       spi_sck = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_mosi = 1'b0;
    logic       host_hold = 1'b1;
    logic [7:0] bus_dout;
    logic       bus_oe, host_irq, cpu_rst_n;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    bit started = 0;

    // frame description shared with the model
    int          tb_nbits = 0;
    logic [15:0] tb_word = '0;

    // model state
    logic [7:0] m_dat = '0, m_off = '0, m_hdat = '0, m_hoff = '0;
    bit         m_pend = 0;
    logic [3:0] m_cs = '1;
    logic [7:0] e_dout = '0;
    logic       e_oe = 0, e_irq = 0, e_crst = 0;
    string      e_tag = "R1";

    always #4 clk = ~clk;

    opinj_responder uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rnw(cpu_rnw),
        .cpu_phi2(cpu_phi2), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .host_hold(host_hold), .bus_dout(bus_dout),
        .bus_oe(bus_oe), .host_irq(host_irq), .cpu_rst_n(cpu_rst_n)
    );

    function automatic logic [7:0] slot_byte(input logic [2:0] s,
                                             input logic [7:0] d, input logic [7:0] o);
        case (s)
            3'd0: return 8'hA0;
            3'd1: return d;
            3'd2: return 8'h8C;
            3'd3: return o;
            3'd4: return 8'h40;
            default: return 8'h00;
        endcase
    endfunction

    // Reference model, evaluated at each rising clock.
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            e_dout = 8'h00; e_oe = 0; e_irq = 0; e_crst = 0; e_tag = "R1";
            m_dat = '0; m_off = '0; m_pend = 0; m_cs = '1;
        end else begin
            e_dout = slot_byte(cpu_addr, m_dat, m_off);
            e_tag  = (cpu_addr == 3'd1 || cpu_addr == 3'd3) ? "R3" :
                     (cpu_addr > 3'd4) ? "R4" : "R2";
            e_oe   = cpu_rnw && cpu_phi2;
            e_irq  = (cpu_addr == 3'd3) && cpu_rnw;
            e_crst = !host_hold;
            m_cs   = {m_cs[2:0], spi_cs_n};
            if (m_cs[2] && !m_cs[3] && tb_nbits == 16) begin
                m_hoff = tb_word[15:8];
                m_hdat = tb_word[7:0];
                m_pend = 1;
            end
            if (m_pend && cpu_addr != 3'd1 && cpu_addr != 3'd3) begin
                m_dat = m_hdat; m_off = m_hoff; m_pend = 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (started && !done) begin
            chk(e_tag, {24'd0, bus_dout}, {24'd0, e_dout});
            chk("R6 bus_oe", {31'd0, bus_oe}, {31'd0, e_oe});
            chk("R5 host_irq", {31'd0, host_irq}, {31'd0, e_irq});
            chk("R7 cpu_rst_n", {31'd0, cpu_rst_n}, {31'd0, e_crst});
        end
    end

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [31:0] v, input int n);
        tb_nbits = n;
        tb_word  = v[15:0];
        spi_cs_n = 1'b0;
        ticks(4);
        for (int i = n - 1; i >= 0; i--) begin
            spi_mosi = v[i];
            ticks(4);
            spi_sck = 1'b1;
            ticks(4);
            spi_sck = 1'b0;
        end
        ticks(4);
        spi_cs_n = 1'b1;
        ticks(6);
    endtask

    task automatic run_cpu(input int rounds);
        for (int r = 0; r < rounds; r++) begin
            for (int s = 0; s < 8; s++) begin
                cpu_addr = 3'(s);
                for (int c = 0; c < 6; c++) begin
                    cpu_phi2 = (c >= 3);
                    ticks(1);
                end
            end
        end
    endtask

    initial begin
        ticks(3);
        chk("R1 reset dout", {24'd0, bus_dout}, 32'h00);
        chk("R1 reset cpu_rst_n", {31'd0, cpu_rst_n}, 32'd0);
        rst_n = 1'b1;
        ticks(2);
        // R8: preload the pair while the processor is held
        send_frame(32'h175A, 16);
        ticks(2);
        host_hold = 1'b0;
        ticks(2);
        chk("R7 released", {31'd0, cpu_rst_n}, 32'd1);
        run_cpu(2);
        cpu_addr = 3'd1; ticks(2);
        chk("R8 data byte", {24'd0, bus_dout}, 32'h5A);
        cpu_addr = 3'd3; ticks(2);
        chk("R8 offset byte", {24'd0, bus_dout}, 32'h17);
        chk("R5 irq on offset", {31'd0, host_irq}, 32'd1);
        // R6: write cycle releases the bus
        cpu_addr = 3'd4; cpu_rnw = 1'b0; cpu_phi2 = 1'b1; ticks(2);
        chk("R6 write released", {31'd0, bus_oe}, 32'd0);
        cpu_rnw = 1'b1; ticks(2);
        chk("R6 read driven", {31'd0, bus_oe}, 32'd1);
        // R10: frame arrives while parked on slot 1
        cpu_addr = 3'd1;
        send_frame(32'h22C3, 16);
        ticks(8);
        chk("R10 deferred", {24'd0, bus_dout}, 32'h5A);
        cpu_addr = 3'd2; ticks(2);
        cpu_addr = 3'd1; ticks(2);
        chk("R10 committed", {24'd0, bus_dout}, 32'hC3);
        // R9: short and long frames are dropped
        cpu_addr = 3'd0;
        send_frame(32'h0ABC, 12);
        send_frame(32'hF1E2D, 20);
        cpu_addr = 3'd1; ticks(2);
        chk("R9 data kept", {24'd0, bus_dout}, 32'hC3);
        cpu_addr = 3'd3; ticks(2);
        chk("R9 offset kept", {24'd0, bus_dout}, 32'h22);
        // Frame landing while the address cycles
        fork
            run_cpu(4);
            send_frame(32'h0899, 16);
        join
        cpu_addr = 3'd1; ticks(2);
        chk("R8 live update", {24'd0, bus_dout}, 32'h99);
        cpu_addr = 3'd3; ticks(2);
        chk("R8 live offset", {24'd0, bus_dout}, 32'h08);
        // R4 / R2 explicit slots
        cpu_addr = 3'd6; ticks(2);
        chk("R4 break", {24'd0, bus_dout}, 32'h00);
        cpu_addr = 3'd2; ticks(2);
        chk("R2 store opcode", {24'd0, bus_dout}, 32'h8C);
        host_hold = 1'b1; ticks(2);
        chk("R7 hold", {31'd0, cpu_rst_n}, 32'd0);
        rst_n = 1'b0; ticks(2);
        chk("R1 reset again", {24'd0, bus_dout}, 32'h00);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule